// File: doc/BRIEF.md
# Key-Guarded Flash Controller Register Bank

This block is the settings and interrupt register bank of a flash memory controller. A simple bus slave port reaches five registers: an interface-setup register, a timing register, an interrupt enable mask, a latched interrupt status, and an unlock key port. The setup and timing registers drive the controller core directly through `cfg_o` and `timing_o`. They can only change after the correct 16-bit key has been written to the key port. Each key grants a single guarded write. After that write the guard closes again without any further action.

Pulses from the controller core set bits in the status register. A status bit stays set until software reads the status register, and that read also clears it. One active-high interrupt line is asserted for as long as any set status bit is also enabled in the mask. Read data is registered and appears one cycle after the read strobe.

Word addresses: 0 setup, 1 timing, 2 mask, 3 status, 4 key port. All other addresses are unmapped.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the guard is closed. The setup, timing, mask and status registers hold zero, and `irq_o` is low.
- R2: A write to address 4 opens the guard only when write data bits [15:0] equal 16'hA25E and both byte enables 0 and 1 are set. Any other write to address 4 closes the guard. A read of address 4 returns the guard state in bit 0 (1 = open).
- R3: While the guard is open, one write to address 0 or address 1 updates the enabled byte lanes of that register and closes the guard. A second write then needs a new key.
- R4: A write to address 0 or address 1 while the guard is closed leaves the register unchanged.
- R5: The setup register is 4 bits wide and is read at address 0 bits [3:0]: bit 3 write protect, bit 2 large-block page, bit 1 five-byte addressing, bit 0 16-bit bus. The timing register is 27 bits wide and is read at address 1 bits [26:0]. Unused upper bits read as zero.
- R6: The mask at address 2, bits [5:0], is written without a key. Writes to the mask or to the status address do not use up an open guard.
- R7: Mask and status share one layout: bit 5 NAND ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault. A one-cycle pulse on `evt_i[n]` sets status bit n at the next clock edge.
- R8: A read of address 3 returns the latched status and clears it in the same access. An event that arrives in the cycle of that read stays set.
- R9: `irq_o` is high exactly while (status AND mask) is non-zero. It rises in the cycle the enabled status bit becomes set.
- R10: `bus_rdata_o` is loaded on the clock edge that samples `bus_re_i` and holds its value otherwise. Unmapped addresses read zero, and writes to the status address or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_be_i | input | DATA_W/8 | Byte enables for writes |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W | Registered read data |
| evt_i | input | 6 | Event pulses from the controller core |
| cfg_o | output | 4 | Interface-setup register contents |
| timing_o | output | TIM_W | Timing register contents |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
A register write takes effect on the rising edge that samples the strobe, and the new value is already on `cfg_o` or `timing_o` before the following falling edge. Read data and the clearing of status follow the same single edge. An event pulse sets its status bit on the next rising edge, and `irq_o` follows within that cycle because it is decoded from registers alone. The bench applies inputs on falling edges and moves its behavioural model on each rising edge. On the next falling edge it compares every output with the model, so each result is sampled half a cycle after the edge that produces it.

// File: rtl/flash_regs_pkg.sv
`timescale 1ns/1ps
package flash_regs_pkg;
   // word offsets on the slave port
   localparam int unsigned OFS_CFG = 0;
   localparam int unsigned OFS_TIM = 1;
   localparam int unsigned OFS_MSK = 2;
   localparam int unsigned OFS_STS = 3;
   localparam int unsigned OFS_KEY = 4;

   // setup register fields
   localparam int unsigned CFG_W        = 4;
   localparam int unsigned CFG_WIDE_BUS = 0;
   localparam int unsigned CFG_LONG_ADR = 1;
   localparam int unsigned CFG_BIG_PAGE = 2;
   localparam int unsigned CFG_WR_PROT  = 3;

   // event / mask / status fields
   localparam int unsigned EVT_W        = 6;
   localparam int unsigned EVT_WP_FAULT = 0;
   localparam int unsigned EVT_ECC_RDY  = 1;
   localparam int unsigned EVT_DEC_ERR  = 2;
   localparam int unsigned EVT_DEC_FAIL = 3;
   localparam int unsigned EVT_CTL_RDY  = 4;
   localparam int unsigned EVT_NAND_RDY = 5;

   localparam int unsigned KEY_W = 16;
endpackage

// File: rtl/flash_key_lock.sv
`timescale 1ns/1ps
module flash_key_lock #(
   parameter int unsigned KEY_W = 16,
   parameter logic [KEY_W-1:0] KEY = 16'hA25E
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             key_wr_i,
   input  logic [KEY_W-1:0] key_i,
   input  logic             key_full_i,
   input  logic             prot_wr_i,
   output logic             open_o
);
   logic open_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        open_q <= 1'b0;
      else if (key_wr_i)  open_q <= key_full_i && (key_i == KEY);
      else if (prot_wr_i) open_q <= 1'b0;
   end

   assign open_o = open_q;

   // R2: the correct key with full lanes opens the guard
   assert_key_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (key_wr_i && key_full_i && key_i == KEY) |=> open_q);

   // R3: a guarded write consumes the grant
   assert_lock_rearm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prot_wr_i && open_q && !key_wr_i) |=> !open_q);
endmodule

// File: rtl/flash_prot_reg.sv
`timescale 1ns/1ps
module flash_prot_reg #(
   parameter int unsigned W       = 8,
   parameter bit          GUARDED = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_i,
   input  logic                 unlocked_i,
   input  logic [W-1:0]         wdata_i,
   input  logic [(W+7)/8-1:0]   be_i,
   output logic [W-1:0]         q_o
);
   localparam int unsigned LANES = (W + 7) / 8;

   logic         commit;
   logic [W-1:0] bit_en;
   logic [W-1:0] q_q;

   if (W == 0) begin : g_bad_w
      $error("flash_prot_reg: W must be non-zero");
   end

   if (GUARDED) begin : g_guarded
      assign commit = wr_i & unlocked_i;
      // R4: a write with the guard closed leaves the contents alone
      assert_closed_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_i && !unlocked_i) |=> $stable(q_q));
   end else begin : g_free
      assign commit = wr_i;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_en[i] = commit & be_i[i / 8];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= (q_q & ~bit_en) | (wdata_i & bit_en);
   end

   assign q_o = q_q;

   initial begin
      assert (LANES >= 1) else $error("flash_prot_reg: no byte lane");
   end
endmodule

// File: rtl/flash_evt_status.sv
`timescale 1ns/1ps
module flash_evt_status #(
   parameter int unsigned N = 6
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] evt_i,
   input  logic         clr_i,
   output logic [N-1:0] sts_o
);
   logic [N-1:0] sts_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      // an event wins over a clearing read in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       sts_q[i] <= 1'b0;
         else if (evt_i[i]) sts_q[i] <= 1'b1;
         else if (clr_i)    sts_q[i] <= 1'b0;
      end

      // R7: a pulse is latched at the next edge (R8: even during a clearing read)
      assert_evt_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         evt_i[i] |=> sts_q[i]);

      // R8: a read without a new event empties the bit
      assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i && !evt_i[i]) |=> !sts_q[i]);
   end

   assign sts_o = sts_q;
endmodule

// File: rtl/flash_ctl_regs.sv
`timescale 1ns/1ps
module flash_ctl_regs
   import flash_regs_pkg::*;
#(
   parameter int unsigned      DATA_W     = 32,
   parameter int unsigned      ADDR_W     = 4,
   parameter int unsigned      TIM_W      = 27,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA25E
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   input  logic [DATA_W/8-1:0] bus_be_i,
   input  logic                bus_we_i,
   input  logic                bus_re_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   input  logic [EVT_W-1:0]    evt_i,
   output logic [CFG_W-1:0]    cfg_o,
   output logic [TIM_W-1:0]    timing_o,
   output logic                irq_o
);
   localparam int unsigned CFG_LN = (CFG_W + 7) / 8;
   localparam int unsigned TIM_LN = (TIM_W + 7) / 8;
   localparam int unsigned EVT_LN = (EVT_W + 7) / 8;

   if (DATA_W % 8 != 0)  begin : g_chk_bytes $error("DATA_W must be whole bytes"); end
   if (DATA_W < KEY_W)   begin : g_chk_key   $error("DATA_W too narrow for key"); end
   if (TIM_W > DATA_W)   begin : g_chk_tim   $error("TIM_W exceeds DATA_W"); end
   if (TIM_W == 0)       begin : g_chk_tim0  $error("TIM_W must be non-zero"); end
   if (ADDR_W < 3)       begin : g_chk_addr  $error("ADDR_W too small for map"); end

   logic hit_cfg, hit_tim, hit_msk, hit_sts, hit_key, hit_any;
   logic lock_open, prot_wr, key_wr;
   logic [CFG_W-1:0]  cfg_q;
   logic [TIM_W-1:0]  tim_q;
   logic [EVT_W-1:0]  msk_q, sts_q;
   logic [DATA_W-1:0] rd_mux, rdata_q;
   logic              unused_bits;

   assign hit_cfg = (bus_addr_i == ADDR_W'(OFS_CFG));
   assign hit_tim = (bus_addr_i == ADDR_W'(OFS_TIM));
   assign hit_msk = (bus_addr_i == ADDR_W'(OFS_MSK));
   assign hit_sts = (bus_addr_i == ADDR_W'(OFS_STS));
   assign hit_key = (bus_addr_i == ADDR_W'(OFS_KEY));
   assign hit_any = hit_cfg | hit_tim | hit_msk | hit_sts | hit_key;

   assign key_wr  = bus_we_i & hit_key;
   assign prot_wr = bus_we_i & (hit_cfg | hit_tim);

   flash_key_lock #(.KEY_W(KEY_W), .KEY(UNLOCK_KEY)) u_lock (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .key_wr_i   (key_wr),
      .key_i      (bus_wdata_i[KEY_W-1:0]),
      .key_full_i (&bus_be_i[1:0]),
      .prot_wr_i  (prot_wr),
      .open_o     (lock_open)
   );

   flash_prot_reg #(.W(CFG_W), .GUARDED(1'b1)) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bus_we_i & hit_cfg),
      .unlocked_i (lock_open),
      .wdata_i    (bus_wdata_i[CFG_W-1:0]),
      .be_i       (bus_be_i[CFG_LN-1:0]),
      .q_o        (cfg_q)
   );

   flash_prot_reg #(.W(TIM_W), .GUARDED(1'b1)) u_tim (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bus_we_i & hit_tim),
      .unlocked_i (lock_open),
      .wdata_i    (bus_wdata_i[TIM_W-1:0]),
      .be_i       (bus_be_i[TIM_LN-1:0]),
      .q_o        (tim_q)
   );

   flash_prot_reg #(.W(EVT_W), .GUARDED(1'b0)) u_msk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bus_we_i & hit_msk),
      .unlocked_i (1'b1),
      .wdata_i    (bus_wdata_i[EVT_W-1:0]),
      .be_i       (bus_be_i[EVT_LN-1:0]),
      .q_o        (msk_q)
   );

   flash_evt_status #(.N(EVT_W)) u_sts (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i),
      .clr_i  (bus_re_i & hit_sts),
      .sts_o  (sts_q)
   );

   always_comb begin
      rd_mux = '0;
      if (hit_cfg)      rd_mux[CFG_W-1:0] = cfg_q;
      else if (hit_tim) rd_mux[TIM_W-1:0] = tim_q;
      else if (hit_msk) rd_mux[EVT_W-1:0] = msk_q;
      else if (hit_sts) rd_mux[EVT_W-1:0] = sts_q;
      else if (hit_key) rd_mux[0]         = lock_open;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_q <= '0;
      else if (bus_re_i) rdata_q <= rd_mux;
   end

   assign bus_rdata_o = rdata_q;
   assign cfg_o       = cfg_q;
   assign timing_o    = tim_q;
   assign irq_o       = |(sts_q & msk_q);
   assign unused_bits = ^{bus_wdata_i, bus_be_i};

   // R9: an enabled event raises the line in the cycle its status bit sets
   assert_irq_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|(evt_i & msk_q)) && !(bus_we_i && hit_msk)) |=> irq_o);

   // R10: unmapped reads return zero
   assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_re_i && !hit_any) |=> (bus_rdata_o == '0));
endmodule

// File: tb/flash_ctl_regs_tb.sv
`timescale 1ns/1ps
module flash_ctl_regs_tb;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int TW = 27;
   localparam int EW = 6;
   localparam int CW = 4;
   localparam logic [15:0] KEY = 16'hA25E;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [AW-1:0] addr  = '0;
   logic [DW-1:0] wdata = '0;
   logic [3:0]    be    = '0;
   logic          we    = 1'b0;
   logic          re    = 1'b0;
   logic [EW-1:0] evt   = '0;
   logic [DW-1:0] rdata;
   logic [CW-1:0] cfg;
   logic [TW-1:0] tim;
   logic          irq;

   flash_ctl_regs #(.DATA_W(DW), .ADDR_W(AW), .TIM_W(TW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_be_i(be), .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata),
      .evt_i(evt), .cfg_o(cfg), .timing_o(tim), .irq_o(irq));

   int    vectors = 0;
   int    errors  = 0;
   bit    done    = 1'b0;
   string cur_req = "R1";

   // behavioural reference model
   logic [CW-1:0] m_cfg;
   logic [TW-1:0] m_tim;
   logic [EW-1:0] m_msk, m_sts;
   logic          m_open;
   logic [DW-1:0] m_rdata, m_rv;

   function automatic logic [31:0] merge(input logic [31:0] old_v, input logic [31:0] new_v,
                                         input logic [3:0] lanes);
      logic [31:0] r;
      r = old_v;
      for (int b = 0; b < 4; b++) if (lanes[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = '0; m_tim = '0; m_msk = '0; m_sts = '0; m_open = 1'b0; m_rdata = '0;
      end else begin
         if (re) begin
            m_rv = '0;
            case (addr)
               4'd0: m_rv[CW-1:0] = m_cfg;
               4'd1: m_rv[TW-1:0] = m_tim;
               4'd2: m_rv[EW-1:0] = m_msk;
               4'd3: m_rv[EW-1:0] = m_sts;
               4'd4: m_rv[0]      = m_open;
               default: ;
            endcase
            m_rdata = m_rv;
         end
         m_sts = ((re && addr == 4'd3) ? '0 : m_sts) | evt;
         if (we) begin
            case (addr)
               4'd0: if (m_open) begin
                  m_cfg = CW'(merge(32'(m_cfg), wdata, be)); m_open = 1'b0;
               end
               4'd1: if (m_open) begin
                  m_tim = TW'(merge(32'(m_tim), wdata, be)); m_open = 1'b0;
               end
               4'd2: m_msk = EW'(merge(32'(m_msk), wdata, be));
               4'd4: m_open = (be[1:0] == 2'b11) && (wdata[15:0] == KEY);
               default: ;
            endcase
         end
      end
   end

   // compare every cycle, half a period after the updating edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         vectors++;
         if (rdata !== m_rdata) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h", cur_req, rdata, m_rdata);
         end
         if (irq !== |(m_sts & m_msk)) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", cur_req, irq, |(m_sts & m_msk));
         end
         if (cfg !== m_cfg) begin
            errors++;
            $display("FAIL %s cfg actual %h expected %h", cur_req, cfg, m_cfg);
         end
         if (tim !== m_tim) begin
            errors++;
            $display("FAIL %s timing actual %h expected %h", cur_req, tim, m_tim);
         end
      end
   end

   task automatic cyc(input logic w, input logic r, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [3:0] b, input logic [EW-1:0] e);
      @(negedge clk);
      we = w; re = r; addr = a; wdata = d; be = b; evt = e;
   endtask
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] b);
      cyc(1'b1, 1'b0, a, d, b, '0);
   endtask
   task automatic rd(input logic [AW-1:0] a);
      cyc(1'b0, 1'b1, a, '0, 4'h0, '0);
   endtask
   task automatic idle();
      cyc(1'b0, 1'b0, '0, '0, 4'h0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      idle(); idle();
      rd(4'd0); rd(4'd1); rd(4'd2); rd(4'd3); rd(4'd4); idle();

      cur_req = "R4";
      wr(4'd0, 32'hF, 4'hF); wr(4'd1, 32'h7FF_FFFF, 4'hF); rd(4'd0); rd(4'd1); idle();

      cur_req = "R2";
      wr(4'd4, {16'h0, KEY}, 4'h3); rd(4'd4);
      wr(4'd4, 32'h0000_1234, 4'hF); rd(4'd4);
      wr(4'd4, {16'h0, KEY}, 4'h1); rd(4'd4);
      wr(4'd0, 32'h5, 4'hF); rd(4'd0); idle();

      cur_req = "R3";
      wr(4'd4, {16'hBEEF, KEY}, 4'hF); wr(4'd0, 32'hB, 4'hF);
      wr(4'd0, 32'h4, 4'hF); rd(4'd0); rd(4'd4);
      wr(4'd4, {16'h0, KEY}, 4'hF); wr(4'd1, 32'hFFFF_FFFF, 4'h5); rd(4'd1);
      wr(4'd1, 32'h0, 4'hF); rd(4'd1); idle();

      cur_req = "R5";
      wr(4'd4, {16'h0, KEY}, 4'hF); wr(4'd0, 32'hFFFF_FFF6, 4'hF); rd(4'd0);
      wr(4'd4, {16'h0, KEY}, 4'hF); wr(4'd1, 32'hFFFF_FFFF, 4'hF); rd(4'd1); idle();

      cur_req = "R6";
      wr(4'd4, {16'h0, KEY}, 4'hF); wr(4'd2, 32'hFFFF_FFFF, 4'hF);
      wr(4'd3, 32'hFF, 4'hF); rd(4'd4); rd(4'd2);
      wr(4'd0, 32'h1, 4'hF); rd(4'd0); rd(4'd4); idle();

      cur_req = "R7";
      wr(4'd2, 32'h0, 4'hF);
      cyc(1'b0, 1'b0, '0, '0, 4'h0, 6'b100001); idle();
      cyc(1'b0, 1'b0, '0, '0, 4'h0, 6'b011110); idle();
      rd(4'd3); idle(); rd(4'd3); idle();

      cur_req = "R9";
      wr(4'd2, 32'h10, 4'hF);
      cyc(1'b0, 1'b0, '0, '0, 4'h0, 6'b001000); idle();
      cyc(1'b0, 1'b0, '0, '0, 4'h0, 6'b010000); idle(); idle();
      wr(4'd2, 32'h08, 4'hF); idle();
      wr(4'd2, 32'h00, 4'hF); idle();

      cur_req = "R8";
      wr(4'd2, 32'h3F, 4'hF);
      cyc(1'b0, 1'b0, '0, '0, 4'h0, 6'b000101); idle();
      cyc(1'b0, 1'b1, 4'd3, '0, 4'h0, 6'b000010); idle();
      rd(4'd3); idle(); rd(4'd3); idle();

      cur_req = "R10";
      rd(4'd7); idle(); rd(4'd15);
      cyc(1'b0, 1'b0, '0, '0, 4'h0, 6'b000001);
      wr(4'd3, 32'h0, 4'hF); wr(4'd9, 32'hFFFF_FFFF, 4'hF);
      rd(4'd3); idle(); idle();

      cur_req = "R2 R3 R4 R6 R8 R9 mix";
      for (int n = 0; n < 3000; n++) begin
         logic [DW-1:0] d;
         logic [3:0]    b;
         d = $urandom;
         if ($urandom_range(0, 1) == 1) d[15:0] = KEY;
         b = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
         cyc(1'($urandom), 1'($urandom), AW'($urandom_range(0, 7)), d, b,
             ($urandom_range(0, 3) == 0) ? EW'($urandom) : '0);
      end
      idle(); idle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule